// File: doc/BRIEF.md
# Triggered Holding-to-Output Transfer Unit for a 12-bit DAC

This block owns the two data registers in front of a 12-bit digital-to-analog converter: a holding register that software writes, and an output register whose code drives the converter. The converter's output level is linear in the output code, with code 4095 meaning full scale. In direct mode every holding-register write is also copied into the output register. In triggered mode the copy waits for a trigger event. The event comes from one of eight sources: seven hardware lines (six timer trigger lines and one external pin line) or a self-clearing software trigger bit.

Each hardware line passes through a two-flop synchronizer and an edge detector, so only a rising edge counts as an event. Once an event is detected, a sequencer waits a fixed latency and then loads the output register from whatever the holding register contains at that moment. A one-cycle load pulse marks every load of the output register.

While a transfer is pending, further events are ignored. A control write that changes the mode or the source select cancels the pending transfer and clears the software bit.

Top module: `dac_xfer_unit`

## Requirements
- R1: After reset the output code, holding register and software trigger bit all read zero, the load pulse is low, and the block is in direct mode.
- R2: In direct mode (`ctrl_trig_en`=0), a holding write issued in cycle W appears on `dac_code` in cycle W+1, together with a one-cycle `load_pulse`. This includes the full-scale code 4095.
- R3: In triggered mode, a holding write changes `hold_q` but leaves `dac_code` unchanged until a trigger event has run its course.
- R4: In triggered mode, select code n from 0 to 6 picks `hw_trig_in[n]` (codes 0 to 5 are the timer lines, code 6 is the external pin line), and code 7 picks the software bit. Edges on lines that are not selected cause no load.
- R5: Only a rising edge on the selected hardware line is an event. A line that is held high causes no further loads, and selecting a line that is already high causes no load.
- R6: Detection happens two cycles after the edge is sampled, and the load becomes visible three cycles after detection. A hardware line first driven high in cycle C therefore gives the new `dac_code` and `load_pulse` in cycle C+5, and no change before that cycle.
- R7: A load copies the holding register as it stands at the load edge. A holding write issued in cycle C+3 (one cycle after detection) is the value loaded in cycle C+5.
- R8: With code 7 selected, a `sw_trig_set` pulse in cycle S sets `sw_trig_q` from S+1. The load is visible in S+4, and `sw_trig_q` reads 0 in that same cycle and not earlier.
- R9: An event that arrives while a transfer is pending is ignored. The pending transfer keeps its original load cycle, and no second load follows.
- R10: A control write that changes the enable or the select cancels any pending transfer, so no load follows. It also clears `sw_trig_q` from the next cycle.
- R11: `dac_code` never changes without `load_pulse` being high in the same cycle, and each triggered load pulses for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_we | input | 1 | Holding register write strobe |
| hold_wdata | input | 12 | Holding register write data |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_trig_en | input | 1 | 1 selects triggered mode, 0 selects direct mode |
| ctrl_src_sel | input | 3 | Trigger source code (0 to 6 hardware lines, 7 software bit) |
| sw_trig_set | input | 1 | Sets the software trigger bit |
| hw_trig_in | input | 7 | Asynchronous hardware trigger lines |
| dac_code | output | 12 | Output register driving the converter |
| hold_q | output | 12 | Holding register contents |
| sw_trig_q | output | 1 | Software trigger bit |
| load_pulse | output | 1 | One-cycle marker of each output-register load |

## Verification
A direct-mode write is due one cycle after its strobe. A hardware edge is due five cycles after the line is raised: two synchronizer cycles, then three cycles of latency. A software trigger is due four cycles after its set pulse. The bench drives every input two nanoseconds after a rising edge and samples at the same offset. It steps exactly the number of edges each result needs and checks that `dac_code` and `load_pulse` stay unchanged in every intermediate cycle, so a load that arrives a cycle early or late is reported. The ignored-event and cancel cases are checked by watching the output for several cycles past the cycle in which a load would have occurred.

// File: rtl/dac_xfer_pkg.sv
package dac_xfer_pkg;

  localparam int DFLT_DATA_W  = 12;
  localparam int DFLT_HW_SRC  = 7;
  localparam int DFLT_LATENCY = 3;
  localparam int DFLT_SYNC    = 2;

  typedef enum logic {
    MODE_DIRECT    = 1'b0,
    MODE_TRIGGERED = 1'b1
  } xfer_mode_e;

  // Select width: hardware sources plus one software code.
  function automatic int sel_width(int n_hw);
    return $clog2(n_hw + 1);
  endfunction

  // The software trigger takes the code just past the hardware lines.
  function automatic int sw_code(int n_hw);
    return n_hw;
  endfunction

  // The counter value in which the load is launched: the register
  // edge at the end of that cycle makes the load visible.
  function automatic int launch_count(int latency);
    return latency - 1;
  endfunction

endpackage

// File: rtl/dac_trig_sync.sv
module dac_trig_sync #(
  parameter int N_LINES = 7,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_i,
  output logic [N_LINES-1:0] rise_o
);

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain <= '0;
        last  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], line_i[g]};
        last  <= chain[STAGES-1];
      end
    end

    assign rise_o[g] = chain[STAGES-1] & ~last;

    // R5: a detected edge lasts one cycle, so a held line cannot retrigger
    a_r5_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end

endmodule

// File: rtl/dac_trig_select.sv
module dac_trig_select #(
  parameter int N_HW  = 7,
  parameter int SEL_W = 3
) (
  input  logic             triggered,
  input  logic [SEL_W-1:0] sel,
  input  logic [N_HW-1:0]  hw_rise,
  input  logic             sw_level,
  output logic             start_req
);

  localparam int SW_CODE = dac_xfer_pkg::sw_code(N_HW);

  always_comb begin
    start_req = 1'b0;
    if (triggered) begin
      for (int i = 0; i < N_HW; i++) begin
        if (sel == SEL_W'(i)) start_req = hw_rise[i];
      end
      if (sel == SEL_W'(SW_CODE)) start_req = sw_level;
    end
  end

endmodule

// File: rtl/dac_xfer_seq.sv
module dac_xfer_seq #(
  parameter int LATENCY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic abort,
  output logic fire_o,
  output logic busy_o
);

  localparam int CNT_W  = $clog2(LATENCY);
  localparam int LAUNCH = dac_xfer_pkg::launch_count(LATENCY);

  logic [CNT_W-1:0] cnt;
  logic             busy;

  assign fire_o = busy && (cnt == CNT_W'(LAUNCH)) && !abort;
  assign busy_o = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (abort || fire_o) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt  <= cnt + 1'b1;
    end else if (start_req) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(1);
    end
  end

  // R9: a pending transfer advances one step per cycle, whatever arrives
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fire_o && !abort |=> busy && cnt == $past(cnt) + 1'b1);

  // R10: a cancel leaves nothing pending
  a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

  // R6: the launch ends the pending state
  a_r6_fire_ends: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !busy);

endmodule

// File: rtl/dac_xfer_unit.sv
module dac_xfer_unit #(
  parameter  int DATA_W      = dac_xfer_pkg::DFLT_DATA_W,
  parameter  int N_HW_SRC    = dac_xfer_pkg::DFLT_HW_SRC,
  parameter  int LATENCY     = dac_xfer_pkg::DFLT_LATENCY,
  parameter  int SYNC_STAGES = dac_xfer_pkg::DFLT_SYNC,
  localparam int SEL_W       = dac_xfer_pkg::sel_width(N_HW_SRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold_we,
  input  logic [DATA_W-1:0]   hold_wdata,
  input  logic                ctrl_we,
  input  logic                ctrl_trig_en,
  input  logic [SEL_W-1:0]    ctrl_src_sel,
  input  logic                sw_trig_set,
  input  logic [N_HW_SRC-1:0] hw_trig_in,
  output logic [DATA_W-1:0]   dac_code,
  output logic [DATA_W-1:0]   hold_q,
  output logic                sw_trig_q,
  output logic                load_pulse
);

  import dac_xfer_pkg::*;

  localparam int SW_CODE = sw_code(N_HW_SRC);

  xfer_mode_e         mode_q;
  logic [SEL_W-1:0]   sel_q;
  logic [N_HW_SRC-1:0] hw_rise;
  logic               start_req;
  logic               fire;
  logic               busy;
  logic               ctrl_change;
  logic               direct_load;
  logic               sw_done;

  assign ctrl_change = ctrl_we &&
                       ((ctrl_trig_en != mode_q) || (ctrl_src_sel != sel_q));
  assign direct_load = hold_we && (mode_q == MODE_DIRECT);
  assign sw_done     = fire && (sel_q == SEL_W'(SW_CODE));

  dac_trig_sync #(.N_LINES(N_HW_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (hw_trig_in),
    .rise_o (hw_rise)
  );

  dac_trig_select #(.N_HW(N_HW_SRC), .SEL_W(SEL_W)) u_select (
    .triggered (mode_q == MODE_TRIGGERED),
    .sel       (sel_q),
    .hw_rise   (hw_rise),
    .sw_level  (sw_trig_q),
    .start_req (start_req)
  );

  dac_xfer_seq #(.LATENCY(LATENCY)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .abort     (ctrl_change),
    .fire_o    (fire),
    .busy_o    (busy)
  );

  // Control and holding registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_DIRECT;
      sel_q  <= '0;
      hold_q <= '0;
    end else begin
      if (ctrl_we) begin
        mode_q <= xfer_mode_e'(ctrl_trig_en);
        sel_q  <= ctrl_src_sel;
      end
      if (hold_we) hold_q <= hold_wdata;
    end
  end

  // Software trigger bit: a cancel beats a set, and a set beats the load clear
  always_ff @(posedge clk) begin
    if (!rst_n)           sw_trig_q <= 1'b0;
    else if (ctrl_change) sw_trig_q <= 1'b0;
    else if (sw_trig_set) sw_trig_q <= 1'b1;
    else if (sw_done)     sw_trig_q <= 1'b0;
  end

  // Output register and its load marker
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_code   <= '0;
      load_pulse <= 1'b0;
    end else begin
      load_pulse <= direct_load || fire;
      if (direct_load)  dac_code <= hold_wdata;
      else if (fire)    dac_code <= hold_q;
    end
  end

  // R11: the output code only moves on a marked load
  a_r11_change_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code != $past(dac_code)) |-> load_pulse);

  // R2: a direct-mode write lands one cycle later
  a_r2_direct_copy: assert property (@(posedge clk) disable iff (!rst_n)
    direct_load |=> load_pulse && dac_code == $past(hold_wdata));

  // R8: the software bit only drops on its load or on a control write
  a_r8_sw_clear_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_trig_q) |-> load_pulse || $past(ctrl_we));

  // R10: a cancelling write is never followed by a launch in the next cycle
  a_r10_no_load_after_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_change && busy |=> !fire);

endmodule

// File: tb/dac_xfer_unit_tb_top.sv
module dac_xfer_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hold_we;
  logic [11:0] hold_wdata;
  logic        ctrl_we;
  logic        ctrl_trig_en;
  logic [2:0]  ctrl_src_sel;
  logic        sw_trig_set;
  logic [6:0]  hw_trig_in;
  logic [11:0] dac_code;
  logic [11:0] hold_q;
  logic        sw_trig_q;
  logic        load_pulse;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int prev;

  always #5 clk = ~clk;

  dac_xfer_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_we      (hold_we),
    .hold_wdata   (hold_wdata),
    .ctrl_we      (ctrl_we),
    .ctrl_trig_en (ctrl_trig_en),
    .ctrl_src_sel (ctrl_src_sel),
    .sw_trig_set  (sw_trig_set),
    .hw_trig_in   (hw_trig_in),
    .dac_code     (dac_code),
    .hold_q       (hold_q),
    .sw_trig_q    (sw_trig_q),
    .load_pulse   (load_pulse)
  );

  // {select code, data}; codes 0..6 are hardware lines, 7 the software bit
  localparam logic [14:0] VEC [0:7] = '{
    {3'd0, 12'h1AC}, {3'd1, 12'hFFF}, {3'd2, 12'h000}, {3'd3, 12'h800},
    {3'd4, 12'h7FF}, {3'd5, 12'hA5A}, {3'd6, 12'h3C3}, {3'd7, 12'h5F0}
  };

  task automatic step(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic write_ctrl(bit en, int sel);
    ctrl_we = 1'b1; ctrl_trig_en = en; ctrl_src_sel = 3'(sel);
    step();
    ctrl_we = 1'b0;
  endtask

  task automatic write_hold(int v);
    hold_we = 1'b1; hold_wdata = 12'(v);
    step();
    hold_we = 1'b0;
  endtask

  // n cycles in which neither the code nor the pulse may move
  task automatic quiet(string tag, int n, int code);
    for (int k = 0; k < n; k++) begin
      step();
      chk({tag, " code held"}, int'(dac_code), code);
      chk({tag, " no pulse"}, int'(load_pulse), 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; hold_we = 1'b0; hold_wdata = '0; ctrl_we = 1'b0;
    ctrl_trig_en = 1'b0; ctrl_src_sel = '0; sw_trig_set = 1'b0; hw_trig_in = '0;
    step(3);
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 dac_code", int'(dac_code), 0);
    chk("R1 hold_q", int'(hold_q), 0);
    chk("R1 sw_trig_q", int'(sw_trig_q), 0);
    chk("R1 load_pulse", int'(load_pulse), 0);

    // R2 direct mode copies each write one cycle later
    write_hold(12'h123);
    chk("R2 code", int'(dac_code), 12'h123);
    chk("R2 pulse", int'(load_pulse), 1);
    write_hold(12'hFFF);
    chk("R2 full scale", int'(dac_code), 12'hFFF);
    step();
    chk("R11 pulse one cycle", int'(load_pulse), 0);
    prev = 12'hFFF;

    // Table walk: R3, R4, R6, R8 per source
    for (int i = 0; i < 8; i++) begin
      int sel = int'(VEC[i][14:12]);
      int dat = int'(VEC[i][11:0]);
      write_ctrl(1'b1, sel);
      write_hold(dat);
      chk("R3 hold_q written", int'(hold_q), dat);
      chk("R3 code untouched", int'(dac_code), prev);
      if (sel < 7) begin
        hw_trig_in[sel] = 1'b1;         // cycle C
        quiet("R6 before C+5", 4, prev);
        step();                          // C+5
        chk("R4/R6 load at C+5", int'(dac_code), dat);
        chk("R6 pulse at C+5", int'(load_pulse), 1);
        hw_trig_in = '0;
        step();
        chk("R11 pulse one cycle", int'(load_pulse), 0);
      end else begin
        sw_trig_set = 1'b1;              // cycle S
        step();
        sw_trig_set = 1'b0;
        chk("R8 bit set S+1", int'(sw_trig_q), 1);
        step(2);                         // S+3
        chk("R8 bit held S+3", int'(sw_trig_q), 1);
        chk("R8 code held S+3", int'(dac_code), prev);
        step();                          // S+4
        chk("R8 load at S+4", int'(dac_code), dat);
        chk("R8 bit cleared with load", int'(sw_trig_q), 0);
        chk("R8 pulse", int'(load_pulse), 1);
        step();
        chk("R11 pulse one cycle", int'(load_pulse), 0);
      end
      prev = dat;
      step(3);
    end

    // R7 late holding write is the one loaded
    write_ctrl(1'b1, 2);
    write_hold(12'h111);
    hw_trig_in[2] = 1'b1;                // C
    step(3);                             // C+3
    hold_we = 1'b1; hold_wdata = 12'h5A5;
    step();                              // C+4
    hold_we = 1'b0;
    chk("R7 code held C+4", int'(dac_code), prev);
    step();                              // C+5
    chk("R7 latest value loaded", int'(dac_code), 12'h5A5);
    prev = 12'h5A5;

    // R5 held-high line gives no second load
    quiet("R5 held high", 6, prev);
    write_hold(12'h777);
    chk("R5 held high after write", int'(dac_code), prev);
    quiet("R5 held high", 6, prev);
    hw_trig_in = '0;
    step(3);

    // R4 unselected line ignored, R5 already-high line ignored on select
    hw_trig_in[4] = 1'b1;
    quiet("R4 unselected line", 8, prev);
    write_ctrl(1'b1, 4);
    quiet("R5 already high", 8, prev);
    hw_trig_in = '0;
    step(3);

    // R9 event during a pending transfer
    write_hold(12'h2C3);
    hw_trig_in[4] = 1'b1;                // C
    step();
    hw_trig_in[4] = 1'b0;                // C+1
    step();
    hw_trig_in[4] = 1'b1;                // C+2, second edge detected at C+4
    step(2);                             // C+4
    chk("R9 code held C+4", int'(dac_code), prev);
    step();                              // C+5
    chk("R9 original load cycle", int'(dac_code), 12'h2C3);
    prev = 12'h2C3;
    write_hold(12'h3D4);
    quiet("R9 no second load", 6, prev);
    hw_trig_in = '0;
    step(3);

    // R10 control change cancels a pending software transfer
    write_ctrl(1'b1, 7);
    write_hold(12'h6E6);
    sw_trig_set = 1'b1;                  // S
    step();
    sw_trig_set = 1'b0;                  // S+1
    step();                              // S+2
    ctrl_we = 1'b1; ctrl_trig_en = 1'b1; ctrl_src_sel = 3'd5;
    step();                              // S+3
    ctrl_we = 1'b0;
    chk("R10 sw bit cleared", int'(sw_trig_q), 0);
    chk("R10 code held", int'(dac_code), prev);
    quiet("R10 no load", 5, prev);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule